// File: doc/BRIEF.md
# Host Clock Output Selector

This block produces the clock that a device drives out to an external host controller. Three sources are available: the 16 MHz main clock, that clock divided by two (8 MHz), and a free-running internal 4 MHz clock. Which one appears on the pin follows the device state. After power-up the device sits in stand-by and the host sees the slow internal clock. On each entry into normal state a strap input picks 8 MHz (strap low) or 16 MHz (strap high), and that choice holds until the next entry into normal state.

Leaving normal state does not by itself change the frequency. Only a crystal fault seen while the device is in stand-by sends the output back to the internal 4 MHz clock. A control-register enable bit turns the pin off altogether. Every change of source, including turning the pin off, goes through a glitch-free handover. The old source finishes its current high phase and is parked low before the new one is allowed through. As a result, no pulse on the pin is shorter than half a period of the faster clock involved.

All inputs are plain, level-sensitive control pins that may change at any time. They are synchronised inside. There is no data stream and no handshake. The selection logic runs on the internal slow clock, so it keeps working when the main clock is suspect.

Top module: `hclk_host_sel`

## Requirements
- R1: While `rst_n` is low, `clk_host` is held at 0.
- R2: After reset, with `dev_normal` low and `out_en` high, `clk_host` carries the 4 MHz `clk_slow` clock.
- R3: When `dev_normal` rises while `strap_16m` is 0, `clk_host` switches to 8 MHz, which is `clk_main` divided by two.
- R4: When `dev_normal` rises while `strap_16m` is 1, `clk_host` switches to the 16 MHz `clk_main`.
- R5: A change of `strap_16m` while `dev_normal` stays high has no effect on the output frequency until the next rise of `dev_normal`.
- R6: When `dev_normal` falls while `xtal_fault` is 0, `clk_host` keeps its 8/16 MHz frequency.
- R7: When `dev_normal` falls while `xtal_fault` is 1, and more generally whenever `xtal_fault` is 1 in stand-by, `clk_host` returns to the 4 MHz clock.
- R8: When `out_en` is 0, `clk_host` parks at 0 and stays there. When `out_en` returns to 1, the clock chosen by the state rules resumes.
- R9: At most one source is passed to `clk_host` at any time, and no high or low pulse on `clk_host` is shorter than 31.25 ns. This holds across source changes and disabling: a high phase in progress is always completed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_main | input | 1 | 16 MHz main clock |
| clk_slow | input | 1 | Internal 4 MHz fallback clock, always running |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_normal | input | 1 | Device state: 1 = normal, 0 = stand-by |
| xtal_fault | input | 1 | Crystal fault indication, 1 = fault |
| strap_16m | input | 1 | Normal-mode frequency strap: 0 = 8 MHz, 1 = 16 MHz |
| out_en | input | 1 | Output enable from a control register, 1 = clock driven |
| clk_host | output | 1 | Clock driven to the host controller |

## Verification
The hardest collision is a source change and the output disable landing together. The bench drops `dev_normal` with `xtal_fault` set at the very instant it clears `out_en`. This asks for a handover to the slow clock and for parking in the same slow-clock cycle. The expected outcome is a silent, low pin with no pulse shorter than 31.25 ns. Re-enabling must then bring up the 4 MHz clock and not the old fast one. A free-running width monitor judges every edge of `clk_host` across the whole run, and windowed edge counts confirm the frequency that the bench's own state model predicts.

// File: rtl/hclk_pkg.sv
`timescale 1ns/1ps
package hclk_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_SLOW = 2'd1,
    SRC_HALF = 2'd2,
    SRC_FULL = 2'd3
  } hsrc_e;

  localparam int N_LEGS      = 3;
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/hclk_sync.sv
`timescale 1ns/1ps
module hclk_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/hclk_mode_fsm.sv
`timescale 1ns/1ps
module hclk_mode_fsm
  import hclk_pkg::*;
#(
  parameter int STAGES = SYNC_STAGES
) (
  input  logic  clk_slow,
  input  logic  rst_n,
  input  logic  dev_normal,
  input  logic  xtal_fault,
  input  logic  strap_16m,
  input  logic  out_en,
  output hsrc_e sel,
  output logic  norm_s,
  output logic  fault_s,
  output logic  strap_s,
  output logic  en_s
);
  localparam int N_IN = 4;

  logic [N_IN-1:0] raw_in, syn_in;
  logic            norm_prev;
  logic            fast_q;
  logic            use16_q;

  assign raw_in = {out_en, strap_16m, xtal_fault, dev_normal};

  hclk_sync #(.STAGES(STAGES), .WIDTH(N_IN)) u_in_sync (
    .clk   (clk_slow),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (syn_in)
  );

  assign norm_s  = syn_in[0];
  assign fault_s = syn_in[1];
  assign strap_s = syn_in[2];
  assign en_s    = syn_in[3];

  // Fast clock is held in normal state; only a fault in stand-by drops it.
  always_ff @(posedge clk_slow or negedge rst_n) begin
    if (!rst_n) begin
      norm_prev <= 1'b0;
      fast_q    <= 1'b0;
      use16_q   <= 1'b0;
    end else begin
      norm_prev <= norm_s;
      if (norm_s) begin
        fast_q <= 1'b1;
        if (!norm_prev) use16_q <= strap_s;
      end else if (fault_s) begin
        fast_q <= 1'b0;
      end
    end
  end

  always_comb begin
    if (!en_s)        sel = SRC_NONE;
    else if (!fast_q) sel = SRC_SLOW;
    else if (use16_q) sel = SRC_FULL;
    else              sel = SRC_HALF;
  end
endmodule

// File: rtl/hclk_div2.sv
`timescale 1ns/1ps
module hclk_div2 (
  input  logic clk_main,
  input  logic rst_n,
  output logic clk_half
);
  always_ff @(posedge clk_main or negedge rst_n) begin
    if (!rst_n) clk_half <= 1'b0;
    else        clk_half <= ~clk_half;
  end
endmodule

// File: rtl/hclk_gf_leg.sv
`timescale 1ns/1ps
module hclk_gf_leg #(
  parameter int STAGES = 2
) (
  input  logic clk_src,
  input  logic rst_n,
  input  logic want,
  input  logic others_off,
  output logic leg_on
);
  logic [STAGES-1:0] chain;

  // Request enters the source domain only once every other leg is parked.
  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], want & others_off};
  end

  // Gate changes only while the source is low: high phases complete.
  always_ff @(negedge clk_src or negedge rst_n) begin
    if (!rst_n) leg_on <= 1'b0;
    else        leg_on <= chain[STAGES-1];
  end
endmodule

// File: rtl/hclk_host_sel.sv
`timescale 1ns/1ps
module hclk_host_sel
  import hclk_pkg::*;
(
  input  logic clk_main,
  input  logic clk_slow,
  input  logic rst_n,
  input  logic dev_normal,
  input  logic xtal_fault,
  input  logic strap_16m,
  input  logic out_en,
  output logic clk_host
);
  hsrc_e             sel;
  logic              norm_s, fault_s, strap_s, en_s;
  logic              clk_half;
  logic [N_LEGS-1:0] leg_clk;
  logic [N_LEGS-1:0] leg_en;

  hclk_mode_fsm #(.STAGES(SYNC_STAGES)) u_fsm (
    .clk_slow   (clk_slow),
    .rst_n      (rst_n),
    .dev_normal (dev_normal),
    .xtal_fault (xtal_fault),
    .strap_16m  (strap_16m),
    .out_en     (out_en),
    .sel        (sel),
    .norm_s     (norm_s),
    .fault_s    (fault_s),
    .strap_s    (strap_s),
    .en_s       (en_s)
  );

  hclk_div2 u_div (
    .clk_main (clk_main),
    .rst_n    (rst_n),
    .clk_half (clk_half)
  );

  // Leg g carries source code g+1: slow, half, full.
  assign leg_clk = {clk_main, clk_half, clk_slow};

  for (genvar g = 0; g < N_LEGS; g++) begin : g_leg
    logic             want_g;
    logic             others_off_g;
    logic [N_LEGS-1:0] mask_g;

    assign mask_g       = ~(N_LEGS'(1) << g);
    assign want_g       = (sel == hsrc_e'(g + 1));
    assign others_off_g = ~|(leg_en & mask_g);

    hclk_gf_leg #(.STAGES(SYNC_STAGES)) u_leg (
      .clk_src    (leg_clk[g]),
      .rst_n      (rst_n),
      .want       (want_g),
      .others_off (others_off_g),
      .leg_on     (leg_en[g])
    );
  end

  assign clk_host = |(leg_clk & leg_en);
endmodule

// File: rtl/hclk_host_sel_chk.sv
`timescale 1ns/1ps
module hclk_host_sel_chk
  import hclk_pkg::*;
(
  input logic       clk_main,
  input logic       clk_slow,
  input logic       rst_n,
  input logic       clk_host,
  input logic [2:0] leg_en,
  input logic [1:0] sel,
  input logic       norm_s,
  input logic       fault_s,
  input logic       strap_s,
  input logic       en_s
);
  assert_quiet_in_reset_R1: assert property (@(posedge clk_main)
    !rst_n |-> !clk_host);

  assert_one_leg_R9: assert property (@(posedge clk_main) disable iff (!rst_n)
    $onehot0(leg_en));

  assert_strap_pick_R3: assert property (@(posedge clk_slow) disable iff (!rst_n)
    ($rose(norm_s) && en_s && !strap_s) |=> (!en_s || sel == SRC_HALF));

  assert_strap_pick_R4: assert property (@(posedge clk_slow) disable iff (!rst_n)
    ($rose(norm_s) && en_s && strap_s) |=> (!en_s || sel == SRC_FULL));

  assert_keep_fast_R6: assert property (@(posedge clk_slow) disable iff (!rst_n)
    ($fell(norm_s) && !fault_s && en_s) |=> (!en_s || sel == SRC_HALF || sel == SRC_FULL));

  assert_fault_slow_R7: assert property (@(posedge clk_slow) disable iff (!rst_n)
    ($fell(norm_s) && fault_s) |=> (sel == SRC_SLOW || sel == SRC_NONE));

  assert_parked_R8: assert property (@(posedge clk_slow) disable iff (!rst_n)
    (sel == SRC_NONE && $past(sel == SRC_NONE, 1) && $past(sel == SRC_NONE, 2)
     && $past(sel == SRC_NONE, 3) && $past(sel == SRC_NONE, 4)) |-> (leg_en == 3'b000));
endmodule

bind hclk_host_sel hclk_host_sel_chk u_chk (
  .clk_main (clk_main),
  .clk_slow (clk_slow),
  .rst_n    (rst_n),
  .clk_host (clk_host),
  .leg_en   (leg_en),
  .sel      (sel),
  .norm_s   (norm_s),
  .fault_s  (fault_s),
  .strap_s  (strap_s),
  .en_s     (en_s)
);

// File: tb/hclk_host_sel_bench.sv
`timescale 1ns/1ps
module hclk_host_sel_bench;
  localparam realtime CLK_PERIOD  = 62.5;
  localparam realtime SLOW_PERIOD = 250.0;
  localparam realtime SETTLE_NS   = 3000.0;
  localparam realtime WINDOW_NS   = 4000.0;
  localparam realtime MIN_PULSE   = 31.0;
  localparam int      WATCHDOG_CYC = 20000;

  logic clk_main = 1'b0;
  logic clk_slow = 1'b0;
  logic rst_n = 1'b1;
  logic dev_normal = 1'b0;
  logic xtal_fault = 1'b0;
  logic strap_16m = 1'b0;
  logic out_en = 1'b1;
  logic clk_host;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Behavioural reference state.
  bit ref_fast = 0;
  bit ref_16 = 0;

  int      edge_cnt = 0;
  int      glitches = 0;
  bit      mon_on = 0;
  realtime last_t = 0.0;

  hclk_host_sel u_hclk_host_sel (
    .clk_main   (clk_main),
    .clk_slow   (clk_slow),
    .rst_n      (rst_n),
    .dev_normal (dev_normal),
    .xtal_fault (xtal_fault),
    .strap_16m  (strap_16m),
    .out_en     (out_en),
    .clk_host   (clk_host)
  );

  always #(CLK_PERIOD/2) clk_main = ~clk_main;
  initial begin
    #17;
    forever #(SLOW_PERIOD/2) clk_slow = ~clk_slow;
  end

  always @(posedge clk_host) edge_cnt++;

  // Width monitor on every output edge (R9).
  always @(clk_host) begin
    if (mon_on) begin
      if ($realtime - last_t < MIN_PULSE) glitches++;
    end
    last_t = $realtime;
  end

  function automatic int expected_edges();
    if (!out_en)   return 0;
    if (!ref_fast) return 16;
    if (ref_16)    return 64;
    return 32;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_normal(input bit v);
    if (v && !dev_normal) ref_16 = strap_16m;
    if (v) ref_fast = 1;
    else if (xtal_fault) ref_fast = 0;
    dev_normal = v;
  endtask

  task automatic set_fault(input bit v);
    xtal_fault = v;
    if (v && !dev_normal) ref_fast = 0;
  endtask

  task automatic measure(input string req);
    int c0, d, e;
    #(SETTLE_NS);
    c0 = edge_cnt;
    #(WINDOW_NS);
    d = edge_cnt - c0;
    e = expected_edges();
    check(d >= e - 1 && d <= e + 1, req, d, e);
    if (e == 0) check(clk_host == 1'b0, req, int'(clk_host), 0);
  endtask

  initial begin
    #2 rst_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      #(CLK_PERIOD * 3.3);
      check(clk_host == 1'b0, "R1", int'(clk_host), 0);
    end
    #(SLOW_PERIOD * 2) rst_n = 1'b1;
    mon_on = 1;

    measure("R2");                       // stand-by after power-up: 4 MHz
    strap_16m = 1'b0; set_normal(1);
    measure("R3");                       // 8 MHz
    strap_16m = 1'b1;
    measure("R5");                       // strap ignored in normal
    set_normal(0);
    measure("R6");                       // leave normal, no fault: keep 8 MHz
    set_normal(1);
    measure("R4");                       // re-entry with strap high: 16 MHz
    out_en = 1'b0;
    measure("R8");                       // parked low
    out_en = 1'b1;
    measure("R8");                       // resumes 16 MHz
    set_fault(1); set_normal(0);
    measure("R7");                       // crystal fault: 4 MHz
    set_fault(0);
    measure("R7");                       // stays slow after fault clears
    strap_16m = 1'b0; set_normal(1);
    measure("R3");
    set_normal(0);
    measure("R6");
    set_normal(1);
    measure("R3");
    // Collision: handover to slow and disable in the same instant.
    set_fault(1); set_normal(0); out_en = 1'b0;
    measure("R8");
    out_en = 1'b1;
    measure("R7");
    set_fault(0);
    check(glitches == 0, "R9", glitches, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYC);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule